// File: doc/BRIEF.md
# Per-Core Interrupt Controller Register Bank

This block is the software-visible register file of a per-core interrupt controller. A processor reaches it over a plain 32-bit read/write bus made of a byte address, read and write strobes, four byte enables, write data and read data. The block decodes each access to one register, merges the enabled byte lanes into it, then applies that register's own rule. A rule may keep only some bits, force some bits to one, keep read-only status bits, or run a side effect. The stored fields are driven out on dedicated ports so that the rest of the controller can use them.

The register slots sit every 16 bytes. A register lives only in the first word of its slot. Offsets that belong to parts of the controller built elsewhere are accepted silently: they read as zero and drop writes. These cover priority arbitration, end of interrupt, the service, trigger and request arrays, and the command words. Any other offset is flagged on `accErr`, as is an access whose byte lanes run past the end of the addressed word. A flagged access changes nothing.

Read data and `accErr` are combinational in the cycle the strobe is high. Writes and read side effects take effect at the clock edge that ends that cycle.

Top module: `core_irq_regs`

## Requirements
- R1: After reset, every register reads zero. The exceptions are the destination format register (0xE0), which reads 0xFFFFFFFF, and the version register (0x30), which reads the VERSION parameter. All field outputs and `errArmed` are zero except `destFmt`, which is 0xF.
- R2: A write to the identifier (0x20) or the task priority (0x80) register stores only bits 7:0. Bits 31:8 read back as zero.
- R3: A write to the logical destination register (0xD0) stores only bits 31:24, and `logDest` shows those bits. Bits 23:0 read as zero.
- R4: The destination format register (0xE0) always reads with bits 27:0 set. Only bits 31:28 take write data, and `destFmt` shows them.
- R5: Writes to the version register (0x30) and the current count register (0x390) have no effect. The current count register always reads zero.
- R6: The six vector table entries sit at 0x320 to 0x370, 16 bytes apart, in entry order 0 to 5 on `lvtFlat` (entry n at bits 32n+31:32n). A write updates every bit of the entry except bits 12 and 14, which keep their stored value.
- R7: The error status register (0x280) always reads zero. A valid write to it while disarmed sets `errArmed`. A valid write while armed clears `errArmed`. A valid read of it clears `errArmed`.
- R8: The spurious vector register (0xF0) stores the full written word. Bit 8 drives `swEnable` and bits 7:0 drive `spurVec`.
- R9: A write to the divide configuration register (0x3E0) keeps only bits 3, 1 and 0 (mask 0xB), and `divCfg` shows them.
- R10: `accErr` is high in the access cycle in any of three cases: the offset maps to no slot, address bits 3:2 are nonzero, or the byte enables shifted left by address bits 1:0 reach beyond byte lane 3. Such a read returns zero and such a write changes nothing.
- R11: Byte lane k of `busWrData` (bits 8k+7:8k) is written only when lane k is enabled. The enabled lanes are `busByteEn` shifted left by address bits 1:0. The register's own rule is then applied to the merged word.
- R12: The out-of-scope offsets are 0x90, 0xA0, 0xB0, 0x100 to 0x27F, 0x300 and 0x310. They raise no `accErr`, read zero and ignore writes.
- R13: The initial count register (0x380) stores all 32 bits and reads them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busByteEn | input | 4 | Byte enables, relative to the address |
| busWrData | input | 32 | Write data, lane aligned |
| busRdData | output | 32 | Read data, valid while busRdEn is high |
| accErr | output | 1 | Reserved or straddling access in this cycle |
| coreId | output | 8 | Stored identifier |
| taskPrio | output | 8 | Stored task priority |
| logDest | output | 8 | Logical destination bits 31:24 |
| destFmt | output | 4 | Destination format bits 31:28 |
| spurVec | output | 8 | Spurious vector number |
| swEnable | output | 1 | Software enable from spurious register bit 8 |
| lvtFlat | output | 32*NUM_LVT | All vector table entries, entry 0 lowest |
| divCfg | output | 4 | Divide configuration field |
| errArmed | output | 1 | Error status write handshake armed |

## Verification
The bench uses the default parameters. ADDR_W is 12, which makes slots above 0x3F (offsets 0x400 and up) reachable, so the unmapped-offset path can be driven. VERSION is 0x00050014, whose distinct non-zero nibbles expose a bit-swapped or dropped version value. NUM_LVT is 6, so every vector table entry is written individually, and each write is checked both on its read port slice and for the preserved status bits.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int NUM_LVT = 6;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_VER, SEL_TPR, SEL_LDR, SEL_DFR, SEL_SVR,
    SEL_ESR, SEL_LVT, SEL_INIT, SEL_CUR, SEL_DIV
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       wr;
    logic       rd;
    regSel_e    sel;
    logic [2:0] lvtIdx;
    logic [3:0] lanes;
  } regStrobe_t;

  localparam logic [31:0] LOW_BYTE_MASK = 32'h0000_00FF;
  localparam logic [31:0] LDR_KEEP_MASK = 32'hFF00_0000;
  localparam logic [31:0] DFR_FORCE_ONE = 32'h0FFF_FFFF;
  localparam logic [31:0] LVT_RO_MASK   = 32'h0000_5000;
  localparam logic [31:0] DIV_KEEP_MASK = 32'h0000_000B;
endpackage

// File: rtl/core_irq_regs_ctrl.sv
module core_irq_regs_ctrl
  import irq_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [3:0]        busByteEn,
  output regStrobe_t        strb,
  output logic              accErr,
  output logic              errArmed
);
  localparam int SLOT_W = ADDR_W - 4;

  logic [SLOT_W-1:0] slot;
  logic [31:0]       slotW;
  logic [7:0]        wideLanes;
  logic              known, straddle, offWord, access, valid;
  regSel_e           sel;
  logic [2:0]        lvtIdx;

  assign slot      = busAddr[ADDR_W-1:4];
  assign slotW     = 32'(slot);
  assign wideLanes = {4'b0, busByteEn} << busAddr[1:0];
  assign straddle  = |wideLanes[7:4];
  assign offWord   = |busAddr[3:2];

  always_comb begin
    sel    = SEL_NONE;
    known  = 1'b1;
    lvtIdx = 3'd0;
    case (slotW)
      32'h02: sel = SEL_ID;
      32'h03: sel = SEL_VER;
      32'h08: sel = SEL_TPR;
      32'h0D: sel = SEL_LDR;
      32'h0E: sel = SEL_DFR;
      32'h0F: sel = SEL_SVR;
      32'h28: sel = SEL_ESR;
      32'h38: sel = SEL_INIT;
      32'h39: sel = SEL_CUR;
      32'h3E: sel = SEL_DIV;
      32'h09, 32'h0A, 32'h0B, 32'h30, 32'h31: sel = SEL_NONE;
      default: begin
        if (slotW >= 32'h32 && slotW <= 32'h32 + NUM_LVT - 1) begin
          sel    = SEL_LVT;
          lvtIdx = 3'(slotW - 32'h32);
        end else if (slotW >= 32'h10 && slotW <= 32'h27) begin
          sel = SEL_NONE;
        end else begin
          known = 1'b0;
        end
      end
    endcase
  end

  assign access = busWrEn | busRdEn;
  assign accErr = access & (~known | straddle | offWord);
  assign valid  = access & ~accErr;

  assign strb.wr     = busWrEn & valid;
  assign strb.rd     = busRdEn & valid;
  assign strb.sel    = sel;
  assign strb.lvtIdx = lvtIdx;
  assign strb.lanes  = wideLanes[3:0];

  // two-step handshake of the error status register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errArmed <= 1'b0;
    end else if (strb.wr && sel == SEL_ESR) begin
      errArmed <= ~errArmed;
    end else if (strb.rd && sel == SEL_ESR) begin
      errArmed <= 1'b0;
    end
  end
endmodule

// File: rtl/core_irq_regs_dp.sv
module core_irq_regs_dp
  import irq_regs_pkg::*;
#(
  parameter logic [31:0] VERSION = 32'h0005_0014
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  regStrobe_t             strb,
  input  logic [31:0]            busWrData,
  output logic [31:0]            busRdData,
  output logic [7:0]             coreId,
  output logic [7:0]             taskPrio,
  output logic [7:0]             logDest,
  output logic [3:0]             destFmt,
  output logic [7:0]             spurVec,
  output logic                   swEnable,
  output logic [32*NUM_LVT-1:0]  lvtFlat,
  output logic [3:0]             divCfg
);
  logic [31:0] laneMask;
  logic [31:0] idReg, tprReg, ldrReg, dfrReg, svrReg, initReg, divReg;
  logic [31:0] lvtReg [NUM_LVT];

  assign laneMask = {{8{strb.lanes[3]}}, {8{strb.lanes[2]}},
                     {8{strb.lanes[1]}}, {8{strb.lanes[0]}}};

  function automatic logic [31:0] mergeLanes(input logic [31:0] oldVal,
                                             input logic [31:0] newVal,
                                             input logic [31:0] msk);
    return (oldVal & ~msk) | (newVal & msk);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idReg   <= '0;
      tprReg  <= '0;
      ldrReg  <= '0;
      dfrReg  <= '1;
      svrReg  <= '0;
      initReg <= '0;
      divReg  <= '0;
    end else if (strb.wr) begin
      case (strb.sel)
        SEL_ID:   idReg   <= mergeLanes(idReg, busWrData, laneMask) & LOW_BYTE_MASK;
        SEL_TPR:  tprReg  <= mergeLanes(tprReg, busWrData, laneMask) & LOW_BYTE_MASK;
        SEL_LDR:  ldrReg  <= mergeLanes(ldrReg, busWrData, laneMask) & LDR_KEEP_MASK;
        SEL_DFR:  dfrReg  <= mergeLanes(dfrReg, busWrData, laneMask) | DFR_FORCE_ONE;
        SEL_SVR:  svrReg  <= mergeLanes(svrReg, busWrData, laneMask);
        SEL_INIT: initReg <= mergeLanes(initReg, busWrData, laneMask);
        SEL_DIV:  divReg  <= mergeLanes(divReg, busWrData, laneMask) & DIV_KEEP_MASK;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_LVT; i++) begin : g_lvt
    logic hit;
    assign hit = strb.wr && strb.sel == SEL_LVT && strb.lvtIdx == 3'(i);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lvtReg[i] <= '0;
      end else if (hit) begin
        lvtReg[i] <= (mergeLanes(lvtReg[i], busWrData, laneMask) & ~LVT_RO_MASK)
                   | (lvtReg[i] & LVT_RO_MASK);
      end
    end
    assign lvtFlat[32*i +: 32] = lvtReg[i];
  end

  always_comb begin
    busRdData = '0;
    if (strb.rd) begin
      case (strb.sel)
        SEL_ID:   busRdData = idReg;
        SEL_VER:  busRdData = VERSION;
        SEL_TPR:  busRdData = tprReg;
        SEL_LDR:  busRdData = ldrReg;
        SEL_DFR:  busRdData = dfrReg;
        SEL_SVR:  busRdData = svrReg;
        SEL_LVT:  busRdData = lvtReg[strb.lvtIdx];
        SEL_INIT: busRdData = initReg;
        SEL_DIV:  busRdData = divReg;
        default:  busRdData = '0;
      endcase
    end
  end

  assign coreId   = idReg[7:0];
  assign taskPrio = tprReg[7:0];
  assign logDest  = ldrReg[31:24];
  assign destFmt  = dfrReg[31:28];
  assign spurVec  = svrReg[7:0];
  assign swEnable = svrReg[8];
  assign divCfg   = divReg[3:0];
endmodule

// File: rtl/core_irq_regs.sv
module core_irq_regs
  import irq_regs_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter logic [31:0] VERSION = 32'h0005_0014
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrEn,
  input  logic                  busRdEn,
  input  logic [3:0]            busByteEn,
  input  logic [31:0]           busWrData,
  output logic [31:0]           busRdData,
  output logic                  accErr,
  output logic [7:0]            coreId,
  output logic [7:0]            taskPrio,
  output logic [7:0]            logDest,
  output logic [3:0]            destFmt,
  output logic [7:0]            spurVec,
  output logic                  swEnable,
  output logic [32*NUM_LVT-1:0] lvtFlat,
  output logic [3:0]            divCfg,
  output logic                  errArmed
);
  regStrobe_t strb;

  core_irq_regs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busByteEn(busByteEn), .strb(strb),
    .accErr(accErr), .errArmed(errArmed)
  );

  core_irq_regs_dp #(.VERSION(VERSION)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWrData(busWrData),
    .busRdData(busRdData), .coreId(coreId), .taskPrio(taskPrio),
    .logDest(logDest), .destFmt(destFmt), .spurVec(spurVec),
    .swEnable(swEnable), .lvtFlat(lvtFlat), .divCfg(divCfg)
  );
endmodule

// File: rtl/core_irq_regs_chk.sv
module core_irq_regs_chk
  import irq_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [ADDR_W-1:0]     busAddr,
  input logic                  busWrEn,
  input logic                  busRdEn,
  input logic [31:0]           busRdData,
  input logic                  accErr,
  input logic [7:0]            coreId,
  input logic [3:0]            destFmt,
  input logic [32*NUM_LVT-1:0] lvtFlat,
  input logic [3:0]            divCfg,
  input logic                  errArmed
);
  logic esrAddr, idAddr, dfrAddr;
  assign esrAddr = busAddr == ADDR_W'('h280);
  assign idAddr  = busAddr == ADDR_W'('h20);
  assign dfrAddr = busAddr == ADDR_W'('hE0);

  a_r7_esr_arm: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && esrAddr && !errArmed) |=> errArmed);

  a_r7_esr_disarm: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && esrAddr && errArmed) |=> !errArmed);

  a_r2_id_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !busWrEn && idAddr) |-> busRdData[31:8] == 24'd0);

  a_r4_dfr_low_ones: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && dfrAddr) |-> busRdData[27:0] == 28'h0FFF_FFFF);

  a_r10_err_rd_zero: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> busRdData == 32'd0);

  a_r10_err_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (accErr && busWrEn) |=> ($stable(coreId) && $stable(destFmt) &&
                             $stable(lvtFlat) && $stable(divCfg)));

  a_r9_div_bit2_clear: assert property (@(posedge clk) disable iff (!rstN)
    divCfg[2] == 1'b0);

  a_r6_lvt_ro_stable: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn |=> $stable(lvtFlat[12]) && $stable(lvtFlat[14]));
endmodule

bind core_irq_regs core_irq_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busRdEn(busRdEn), .busRdData(busRdData), .accErr(accErr),
  .coreId(coreId), .destFmt(destFmt), .lvtFlat(lvtFlat),
  .divCfg(divCfg), .errArmed(errArmed)
);

// File: tb/core_irq_regs_test.sv
module core_irq_regs_test;
  localparam int          ADDR_W  = 12;
  localparam logic [31:0] VERSION = 32'h0005_0014;
  localparam int          NLVT    = 6;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0, busRdEn = 1'b0;
  logic [3:0]        busByteEn = 4'hF;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;
  logic              accErr, swEnable, errArmed;
  logic [7:0]        coreId, taskPrio, logDest, spurVec;
  logic [3:0]        destFmt, divCfg;
  logic [32*NLVT-1:0] lvtFlat;

  int nRun = 0, nFail = 0;
  logic [31:0] rdVal;
  logic        errVal;

  always #4 clk = ~clk;

  core_irq_regs #(.ADDR_W(ADDR_W), .VERSION(VERSION)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busByteEn(busByteEn), .busWrData(busWrData),
    .busRdData(busRdData), .accErr(accErr), .coreId(coreId),
    .taskPrio(taskPrio), .logDest(logDest), .destFmt(destFmt),
    .spurVec(spurVec), .swEnable(swEnable), .lvtFlat(lvtFlat),
    .divCfg(divCfg), .errArmed(errArmed)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    busAddr = a; busWrData = d; busByteEn = be; busWrEn = 1'b1;
    #2 errVal = accErr;
    @(negedge clk);
    busWrEn = 1'b0; busByteEn = 4'hF;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk);
    busAddr = a; busByteEn = 4'hF; busRdEn = 1'b1;
    #2 begin rdVal = busRdData; errVal = accErr; end
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic t_reset;
    rd(12'h020); check("R1 id", rdVal, 0);
    rd(12'h030); check("R1 version", rdVal, VERSION);
    rd(12'h0E0); check("R1 dfr", rdVal, 32'hFFFF_FFFF);
    rd(12'h3E0); check("R1 div", rdVal, 0);
    check("R1 destFmt", 32'(destFmt), 32'hF);
    check("R1 lvt", 32'(|lvtFlat), 0);
    check("R1 armed", 32'(errArmed), 0);
  endtask

  task automatic t_id_tpr;
    wr(12'h020, 32'hFFFF_FFA5, 4'hF);
    rd(12'h020); check("R2 id read", rdVal, 32'h0000_00A5);
    check("R2 coreId", 32'(coreId), 32'hA5);
    wr(12'h080, 32'h1234_5678, 4'hF);
    rd(12'h080); check("R2 tpr read", rdVal, 32'h78);
    check("R2 taskPrio", 32'(taskPrio), 32'h78);
  endtask

  task automatic t_ldr_dfr;
    wr(12'h0D0, 32'hABCD_EF12, 4'hF);
    rd(12'h0D0); check("R3 ldr read", rdVal, 32'hAB00_0000);
    check("R3 logDest", 32'(logDest), 32'hAB);
    wr(12'h0E0, 32'h5000_0000, 4'hF);
    rd(12'h0E0); check("R4 dfr read", rdVal, 32'h5FFF_FFFF);
    check("R4 destFmt", 32'(destFmt), 32'h5);
  endtask

  task automatic t_readonly;
    wr(12'h030, 32'hDEAD_BEEF, 4'hF);
    rd(12'h030); check("R5 version unchanged", rdVal, VERSION);
    wr(12'h390, 32'hDEAD_BEEF, 4'hF);
    rd(12'h390); check("R5 current count", rdVal, 0);
  endtask

  task automatic t_lvt;
    for (int i = 0; i < NLVT; i++) begin
      wr(12'(12'h320 + 16*i), 32'hFFFF_FFFF ^ 32'(i), 4'hF);
      rd(12'(12'h320 + 16*i));
      check("R6 lvt read", rdVal, (32'hFFFF_FFFF ^ 32'(i)) & ~32'h0000_5000);
      check("R6 lvt port", lvtFlat[32*i +: 32], (32'hFFFF_FFFF ^ 32'(i)) & ~32'h0000_5000);
    end
    wr(12'h340, 32'h0000_0000, 4'hF);
    check("R6 lvt cleared", lvtFlat[64 +: 32], 0);
    check("R6 lvt neighbour", lvtFlat[96 +: 32], 32'hFFFF_AFFC);
  endtask

  task automatic t_esr;
    check("R7 start", 32'(errArmed), 0);
    wr(12'h280, 32'hFFFF_FFFF, 4'hF);
    check("R7 armed", 32'(errArmed), 1);
    wr(12'h280, 32'hFFFF_FFFF, 4'hF);
    check("R7 disarmed", 32'(errArmed), 0);
    wr(12'h280, 32'h0, 4'hF);
    check("R7 rearmed", 32'(errArmed), 1);
    rd(12'h280);
    check("R7 read zero", rdVal, 0);
    check("R7 read disarms", 32'(errArmed), 0);
  endtask

  task automatic t_svr_div;
    wr(12'h0F0, 32'h0000_01FF, 4'hF);
    check("R8 swEnable", 32'(swEnable), 1);
    check("R8 spurVec", 32'(spurVec), 32'hFF);
    rd(12'h0F0); check("R8 read", rdVal, 32'h1FF);
    wr(12'h0F0, 32'h0000_00EF, 4'hF);
    check("R8 swEnable off", 32'(swEnable), 0);
    wr(12'h3E0, 32'hFFFF_FFFF, 4'hF);
    rd(12'h3E0); check("R9 div read", rdVal, 32'hB);
    check("R9 divCfg", 32'(divCfg), 32'hB);
  endtask

  task automatic t_errors;
    rd(12'h024); check("R10 offword err", 32'(errVal), 1);
    check("R10 offword data", rdVal, 0);
    rd(12'h400); check("R10 unmapped err", 32'(errVal), 1);
    wr(12'h3F0, 32'hFFFF_FFFF, 4'hF); check("R10 reserved wr err", 32'(errVal), 1);
    wr(12'h022, 32'h0000_0011, 4'hF); check("R10 straddle err", 32'(errVal), 1);
    check("R10 id unchanged", 32'(coreId), 32'hA5);
    wr(12'h281, 32'h0, 4'hF); check("R10 esr straddle", 32'(errArmed), 0);
  endtask

  task automatic t_lanes;
    wr(12'h380, 32'hFFFF_FFFF, 4'hF);
    rd(12'h380); check("R13 init full", rdVal, 32'hFFFF_FFFF);
    wr(12'h380, 32'h0, 4'h2);
    rd(12'h380); check("R11 lane1 only", rdVal, 32'hFFFF_00FF);
    wr(12'h382, 32'h0, 4'h3);
    check("R11 shifted lanes ok", 32'(errVal), 0);
    rd(12'h380); check("R11 shifted lanes", rdVal, 32'h0000_00FF);
  endtask

  task automatic t_oos;
    wr(12'h090, 32'hFFFF_FFFF, 4'hF); check("R12 0x90 no err", 32'(errVal), 0);
    wr(12'h100, 32'hFFFF_FFFF, 4'hF); check("R12 0x100 no err", 32'(errVal), 0);
    wr(12'h300, 32'hFFFF_FFFF, 4'hF);
    rd(12'h300); check("R12 0x300 reads zero", rdVal, 0);
    check("R12 0x300 rd no err", 32'(errVal), 0);
    rd(12'h270); check("R12 0x270 reads zero", rdVal, 0);
    rd(12'h080); check("R12 tpr untouched", rdVal, 32'h78);
  endtask

  initial begin
    #(8 * 100000);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset;
    t_id_tpr;
    t_ldr_dfr;
    t_readonly;
    t_lvt;
    t_esr;
    t_svr_div;
    t_errors;
    t_lanes;
    t_oos;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule